// File: doc/BRIEF.md
# Instruction Result Display Formatter

This block turns the values exported by a small processor after each executed instruction into a four-digit hexadecimal readout on a time-multiplexed, common-anode seven-segment display. When the processor signals completion, the block captures the instruction class and up to three 4-bit values. It then holds them until the next completion or a clear request, so the readout stays steady between instructions.

A memory transfer (load or store) is shown as two zeros, a dash and the transferred value. An arithmetic instruction (add or subtract) is shown as operand A, operand B, a dash and the 4-bit result. A free-running divider steps a scan counter that lights one digit at a time. Segment lines and digit enables are active-low.

Top module: `result_display`

## Requirements
- R1: On a clock edge with `done_i`=1, `clear_i`=0 and `class_i`=2'b01 (transfer), the digits from left (`an_no[3]`) to right (`an_no[0]`) become 0, 0, dash, `val_r_i`.
- R2: On a clock edge with `done_i`=1, `clear_i`=0 and `class_i`=2'b10 (arithmetic), the digits from left to right become `val_a_i`, `val_b_i`, dash, `val_r_i`. The result digit shows `val_r_i` as given, so A=5 and B=7 under add show 5, 7, dash, C.
- R3: On a clock edge with `done_i`=1, `clear_i`=0 and `class_i` equal to 2'b00 or 2'b11, all four digits become blank.
- R4: A clock edge with `clear_i`=1 blanks all digits from the next cycle on, even if `done_i` is also 1 on that edge. The digits stay blank until a later edge with `done_i`=1 and `clear_i`=0.
- R5: Changes on `class_i` and the value inputs have no effect on the display while `done_i` is 0.
- R6: `seg_no[6:0]` is active-low, with bit 0 driving segment a and bit 6 driving segment g. The active-high gfedcba patterns for hex 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.
- R7: A dash lights only segment g (`seg_no`=7'h3F). A blank digit lights no segment (`seg_no`=7'h7F).
- R8: Exactly one bit of `an_no` is 0 in every cycle. The lit digit steps from `an_no[0]` to `an_no[1]`, `an_no[2]`, `an_no[3]` and back to `an_no[0]`. Each digit stays lit for CLK_HZ/SCAN_HZ cycles.
- R9: During and after reset, the display is blank and `an_no` is 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Instruction completion strobe; captures class and values |
| class_i | input | 2 | Instruction class: 01 transfer, 10 arithmetic, 00/11 none |
| val_a_i | input | 4 | Operand A |
| val_b_i | input | 4 | Operand B |
| val_r_i | input | 4 | Transferred data or arithmetic result |
| clear_i | input | 1 | Blank the display until the next completion |
| seg_no | output | 7 | Segment lines a..g in bits 0..6, active low |
| an_no | output | 4 | Digit enables, bit 0 rightmost, active low |

## Verification
A corrupted capture register shows up at the segment lines as soon as the scan reaches the affected digit, which is at most four scan periods after the completion strobe. A faulty divider or scan counter shows up within one scan period, either as a digit dwell time other than CLK_HZ/SCAN_HZ or as a break in the right-to-left stepping of the enables. A broken clear shows up on the cycle after the request as any lit segment.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned NUM_DIGITS = 4;
  localparam int unsigned SEL_W      = $clog2(NUM_DIGITS);
  localparam int unsigned SEG_W      = 7;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_XFER  = 2'd1,
    CLS_ARITH = 2'd2,
    CLS_RSVD  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    DG_BLANK = 2'd0,
    DG_DASH  = 2'd1,
    DG_HEX   = 2'd2
  } dkind_e;

  typedef struct packed {
    dkind_e     kind;
    logic [3:0] val;
  } digit_t;

  localparam digit_t DIGIT_BLANK = '{kind: DG_BLANK, val: 4'h0};
  localparam digit_t DIGIT_DASH  = '{kind: DG_DASH,  val: 4'h0};

  // active-high gfedcba
  function automatic logic [SEG_W-1:0] hex_to_seg(input logic [3:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/disp_capture.sv
module disp_capture
  import disp_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   done_i,
  input  logic                   clear_i,
  input  logic [1:0]             class_i,
  input  logic [3:0]             val_a_i,
  input  logic [3:0]             val_b_i,
  input  logic [3:0]             val_r_i,
  output digit_t [NUM_DIGITS-1:0] digits_o
);
  digit_t [NUM_DIGITS-1:0] next_d;
  cls_e                    cls;

  assign cls = cls_e'(class_i);

  // index 0 is the rightmost digit
  always_comb begin
    next_d = {NUM_DIGITS{DIGIT_BLANK}};
    case (cls)
      CLS_XFER: begin
        next_d[3] = '{kind: DG_HEX, val: 4'h0};
        next_d[2] = '{kind: DG_HEX, val: 4'h0};
        next_d[1] = DIGIT_DASH;
        next_d[0] = '{kind: DG_HEX, val: val_r_i};
      end
      CLS_ARITH: begin
        next_d[3] = '{kind: DG_HEX, val: val_a_i};
        next_d[2] = '{kind: DG_HEX, val: val_b_i};
        next_d[1] = DIGIT_DASH;
        next_d[0] = '{kind: DG_HEX, val: val_r_i};
      end
      default: next_d = {NUM_DIGITS{DIGIT_BLANK}};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      digits_o <= {NUM_DIGITS{DIGIT_BLANK}};
    else if (clear_i) digits_o <= {NUM_DIGITS{DIGIT_BLANK}};
    else if (done_i)  digits_o <= next_d;
  end
endmodule

// File: rtl/disp_scan.sv
module disp_scan
  import disp_pkg::*;
#(
  parameter int unsigned DIV = 100_000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [SEL_W-1:0]      sel_o,
  output logic [NUM_DIGITS-1:0] an_no
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_o <= '0;
    end else if (step) begin
      cnt_q <= '0;
      sel_o <= sel_o + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_an
    assign an_no[g] = (sel_o != SEL_W'(g));
  end
endmodule

// File: rtl/disp_seg.sv
module disp_seg
  import disp_pkg::*;
(
  input  digit_t           digit_i,
  output logic [SEG_W-1:0] seg_no
);
  logic [SEG_W-1:0] seg_hi;

  always_comb begin
    case (digit_i.kind)
      DG_HEX:  seg_hi = hex_to_seg(digit_i.val);
      DG_DASH: seg_hi = 7'h40;
      default: seg_hi = 7'h00;
    endcase
  end

  assign seg_no = ~seg_hi;
endmodule

// File: rtl/result_display.sv
module result_display
  import disp_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SCAN_HZ = 1_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic [1:0] class_i,
  input  logic [3:0] val_a_i,
  input  logic [3:0] val_b_i,
  input  logic [3:0] val_r_i,
  input  logic       clear_i,
  output logic [6:0] seg_no,
  output logic [3:0] an_no
);
  localparam int unsigned DIV_RAW = CLK_HZ / SCAN_HZ;
  localparam int unsigned DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  digit_t [NUM_DIGITS-1:0] digits;
  logic   [SEL_W-1:0]      sel;

  disp_capture u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done_i),
    .clear_i  (clear_i),
    .class_i  (class_i),
    .val_a_i  (val_a_i),
    .val_b_i  (val_b_i),
    .val_r_i  (val_r_i),
    .digits_o (digits)
  );

  disp_scan #(.DIV(DIV)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_o  (sel),
    .an_no  (an_no)
  );

  disp_seg u_seg (
    .digit_i (digits[sel]),
    .seg_no  (seg_no)
  );
endmodule

// File: rtl/result_display_chk.sv
module result_display_chk #(
  parameter int unsigned DIV = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_i,
  input logic [1:0] class_i,
  input logic       clear_i,
  input logic [6:0] seg_no,
  input logic [3:0] an_no
);
  localparam int unsigned DW = $clog2(DIV + 1) + 1;

  logic [3:0]    an_q;
  logic [DW-1:0] dwell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      an_q    <= 4'b1110;
      dwell_q <= '0;
    end else begin
      an_q    <= an_no;
      dwell_q <= (an_no != an_q) ? DW'(1) : dwell_q + 1'b1;
    end
  end

  p_one_digit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~an_no) == 1);

  p_scan_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_no != an_q) |-> (an_no == {an_q[2:0], an_q[3]}));

  p_dwell_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_no != an_q) |-> (dwell_q == DW'(DIV)));

  p_dwell_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_no == an_q) |-> (dwell_q < DW'(DIV)));

  p_clear_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (seg_no == 7'h7F));

  p_none_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (class_i == 2'b00 || class_i == 2'b11)) |=> (seg_no == 7'h7F));

  p_dash_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clear_i && (class_i == 2'b01 || class_i == 2'b10))
      |=> (an_no[1] || seg_no == 7'h3F));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r9: assert (an_no == 4'b1110 && seg_no == 7'h7F);
    end
  end
endmodule

bind result_display result_display_chk #(.DIV(DIV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_i  (done_i),
  .class_i (class_i),
  .clear_i (clear_i),
  .seg_no  (seg_no),
  .an_no   (an_no)
);

// File: tb/test_result_display.sv
module test_result_display;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8000;
  localparam int SCAN_HZ    = 1000;
  localparam int DIV        = CLK_HZ / SCAN_HZ;

  localparam logic [6:0] SEG_BLANK = 7'h7F;
  localparam logic [6:0] SEG_DASH  = 7'h3F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic [1:0] cls = 2'b00;
  logic [3:0] va = '0, vb = '0, vr = '0;
  logic       clr = 1'b0;
  logic [6:0] seg;
  logic [3:0] an;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_display #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) i_result_display (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .done_i  (done),
    .class_i (cls),
    .val_a_i (va),
    .val_b_i (vb),
    .val_r_i (vr),
    .clear_i (clr),
    .seg_no  (seg),
    .an_no   (an)
  );

  // R6 patterns, returned active-low
  function automatic logic [6:0] hex_al(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~t[v];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_digit(input int pos, output logic [6:0] s);
    do @(negedge clk); while (an !== ~(4'b0001 << pos));
    s = seg;
  endtask

  task automatic check_frame(input string req, input logic [6:0] d3, input logic [6:0] d2,
                             input logic [6:0] d1, input logic [6:0] d0);
    logic [6:0] s;
    read_digit(0, s); check({req, " digit0"}, s, d0);
    read_digit(1, s); check({req, " digit1"}, s, d1);
    read_digit(2, s); check({req, " digit2"}, s, d2);
    read_digit(3, s); check({req, " digit3"}, s, d3);
  endtask

  task automatic pulse(input logic [1:0] c, input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] r, input logic with_clr);
    @(negedge clk);
    cls = c; va = a; vb = b; vr = r; done = 1'b1; clr = with_clr;
    @(negedge clk);
    done = 1'b0; clr = 1'b0;
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    check("R9 reset an", an, 4'b1110);
    check("R9 reset seg", seg, SEG_BLANK);
    @(negedge clk); rst_n = 1'b1;
    check("R9 after reset an", an, 4'b1110);
    check("R9 after reset seg", seg, SEG_BLANK);
  endtask

  task automatic t_transfer;
    pulse(2'b01, 4'h9, 4'h3, 4'h4, 1'b0);
    check_frame("R1 load 4", hex_al(0), hex_al(0), SEG_DASH, hex_al(4'h4));
    for (int v = 0; v < 16; v++) begin
      logic [6:0] s;
      pulse(2'b01, 4'h0, 4'h0, 4'(v), 1'b0);
      read_digit(0, s);
      check($sformatf("R6 hex %0h", v), s, hex_al(4'(v)));
    end
  endtask

  task automatic t_arith;
    pulse(2'b10, 4'h5, 4'h7, 4'hC, 1'b0);
    check_frame("R2 add 5+7", hex_al(4'h5), hex_al(4'h7), SEG_DASH, hex_al(4'hC));
    pulse(2'b10, 4'h3, 4'h8, 4'hB, 1'b0);
    check_frame("R2 sub 3-8", hex_al(4'h3), hex_al(4'h8), SEG_DASH, hex_al(4'hB));
    check_frame("R7 dash only g", hex_al(4'h3), hex_al(4'h8), 7'h3F, hex_al(4'hB));
  endtask

  task automatic t_none;
    pulse(2'b10, 4'h1, 4'h2, 4'h3, 1'b0);
    pulse(2'b00, 4'h1, 4'h2, 4'h3, 1'b0);
    check_frame("R3 class 00", SEG_BLANK, SEG_BLANK, SEG_BLANK, SEG_BLANK);
    pulse(2'b10, 4'h1, 4'h2, 4'h3, 1'b0);
    pulse(2'b11, 4'h1, 4'h2, 4'h3, 1'b0);
    check_frame("R3 class 11", SEG_BLANK, SEG_BLANK, SEG_BLANK, SEG_BLANK);
  endtask

  task automatic t_hold;
    pulse(2'b10, 4'hA, 4'hD, 4'h7, 1'b0);
    @(negedge clk);
    cls = 2'b01; va = 4'h2; vb = 4'h6; vr = 4'hE;
    check_frame("R5 inputs ignored", hex_al(4'hA), hex_al(4'hD), SEG_DASH, hex_al(4'h7));
  endtask

  task automatic t_clear;
    logic [6:0] s;
    pulse(2'b01, 4'h0, 4'h0, 4'h6, 1'b0);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R4 blank next cycle", seg, SEG_BLANK);
    check_frame("R4 stays blank", SEG_BLANK, SEG_BLANK, SEG_BLANK, SEG_BLANK);
    pulse(2'b10, 4'h4, 4'h4, 4'h8, 1'b1);
    check_frame("R4 clear beats done", SEG_BLANK, SEG_BLANK, SEG_BLANK, SEG_BLANK);
    pulse(2'b01, 4'h0, 4'h0, 4'hF, 1'b0);
    read_digit(0, s);
    check("R4 next done restores", s, hex_al(4'hF));
  endtask

  task automatic t_scan;
    logic [3:0] prev;
    int n;
    do @(negedge clk); while (an !== 4'b1110);
    do @(negedge clk); while (an === 4'b1110);
    for (int k = 0; k < 4; k++) begin
      prev = an;
      n = 0;
      while (an === prev) begin
        check("R8 one enable", $countones(~an), 1);
        @(negedge clk); n++;
      end
      check("R8 dwell", n, DIV);
      check("R8 order", an, {prev[2:0], prev[3]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_transfer();
    t_arith();
    t_none();
    t_hold();
    t_clear();
    t_scan();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule